// File: doc/BRIEF.md
# Parallel External Bus Timing Controller

This block connects a simple synchronous request/response slave port to a shared parallel memory bus. Each accepted command becomes a timed access on the bus. A setup phase drives chip select, address and write data ahead of the strobe. A strobe phase of one base cycle plus a programmable wait follows. Writes then get a hold phase, which keeps chip select, address and data steady after the strobe drops. All timing is counted in clock cycles and fixed by parameters.

Every outgoing bus signal passes through one register stage at the pins. Read data passes through another register stage on the way in. A read therefore returns `RD_LAT + 2` cycles after the end of its internal strobe, where `RD_LAT` is the memory's own latency. The controller lets several fixed-latency reads be in flight, up to a programmable limit. A write after a read is held off by a turnaround gap, counted from the cycle the read was accepted. Chip select can optionally stay asserted until every pending read has returned. Each of the seven control outputs has its own polarity parameter, applied only in the pin register.

The slave holds `s_read` or `s_write`, never both at once, until a cycle with `s_waitreq` low. The command is accepted in that cycle.

Top module: `ext_bus_timer`

## Requirements
- R1: While reset is held, and after it: every control pin rests at its inactive level (the value of its INV_* parameter, all bits for the byte-enable vectors) and `s_rvalid` is 0. With no request pending after reset, `s_waitreq` is 0.
- R2: The pins lag the internal sequence by one register. The first strobe pin cycle of an access comes exactly `SETUP_CYC` cycles after its begin-transfer pin cycle. Chip select is active from the begin-transfer cycle on, and the address pin carries the command address when the strobe starts.
- R3: The read strobe pin stays active for `1 + RD_WAIT` consecutive cycles. The write strobe pin stays active for `1 + WR_WAIT` consecutive cycles.
- R4: After a write strobe, chip select, address and write data stay driven for `HOLD_CYC` cycles. For back-to-back commands, the next write or read is accepted `2 + SETUP_CYC + WR_WAIT + HOLD_CYC` cycles after a write. After a read, with no stall, the next command is accepted `2 + SETUP_CYC + RD_WAIT` cycles later. A read has no hold phase.
- R5: For a read accepted in cycle A, `s_rvalid` is high for one cycle at cycle `A + SETUP_CYC + RD_WAIT + RD_LAT + 3`. `s_rdata` then carries the value the memory drove `RD_LAT` cycles after the last strobe pin cycle. Responses return in command order.
- R6: A write is accepted no earlier than `max(TURN_CYC, RD_LAT + 2)` cycles after the most recent read acceptance, and `s_waitreq` is high for a write request inside that window.
- R7: A read is accepted only while fewer than `MAX_PEND` reads are pending. A read is pending from its acceptance until its `s_rvalid` cycle, inclusive. While the limit is reached, `s_waitreq` is high for a read request.
- R8: With `CS_THRU_LAT = 1`, chip select is active in the cycle after any cycle in which a read was pending. With no access and no pending read, chip select returns to inactive.
- R9: A pin's level is its active-high value XOR its own INV_* parameter. With INV = 1, the active level is 0.
- R10: Output enable is active exactly when the read strobe is active. During the write strobe, the write-byte-enable pins equal the command byte enables. Outside the write strobe, all write-byte-enable bits are inactive.
- R11: Begin-transfer is active for exactly one pin cycle per accepted command, at acceptance cycle + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_addr | input | ADDR_W | Command address |
| s_wdata | input | DATA_W | Write data |
| s_be | input | BE_W | Byte enables |
| s_read | input | 1 | Read request, held until accepted |
| s_write | input | 1 | Write request, held until accepted |
| s_waitreq | output | 1 | High: request not accepted this cycle |
| s_rdata | output | DATA_W | Read response data |
| s_rvalid | output | 1 | Read response valid |
| p_addr | output | ADDR_W | Bus address pins |
| p_dout | output | DATA_W | Bus write data pins |
| p_din | input | DATA_W | Bus read data pins |
| p_cs | output | 1 | Chip select pin |
| p_rd | output | 1 | Read strobe pin |
| p_wr | output | 1 | Write strobe pin |
| p_oe | output | 1 | Output enable pin |
| p_be | output | BE_W | Byte enable pins |
| p_wbe | output | BE_W | Write byte enable pins |
| p_bt | output | 1 | Begin-transfer pin |

## Verification
Two functions can land in one cycle: a returning read response, and a new read being judged against the pending limit. When the limit is reached, the response cycle still counts the returning read as pending. The new read must be accepted exactly one cycle after that response. The bench provokes this with three back-to-back reads and checks the third acceptance cycle arithmetically. A near-exhaustive sweep of every four-command read/write ordering also makes turnaround stalls coincide with reads still in flight under held chip select.

// File: rtl/ebt_pkg.sv
// Shared types and helpers for the external bus timing controller.
package ebt_pkg;

    // Access phase of the bus sequencer
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } ebt_state_e;

    // Larger of two integers, used for derived parameter limits
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ebt_seq.sv
// Phase sequencer: walks one accepted access through setup, strobe and
// (writes only) hold, and latches the command for the whole access.
// Assumes go_rd/go_wr only pulse while the sequencer is idle.
module ebt_seq
    import ebt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int BE_W      = 2,
    parameter int SETUP_CYC = 1,
    parameter int RD_WAIT   = 1,
    parameter int WR_WAIT   = 2,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_rd,
    input  logic              go_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [BE_W-1:0]   cmd_be,
    output logic              busy,
    output logic              strobe_rd,
    output logic              strobe_wr,
    output logic              begin_x,
    output logic              rd_done,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [BE_W-1:0]   be_q
);

    localparam int CNT_MAX = imax(imax(SETUP_CYC, HOLD_CYC), imax(RD_WAIT, WR_WAIT));
    localparam int CNT_W   = $clog2(CNT_MAX + 2);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'((SETUP_CYC > 0) ? SETUP_CYC - 1 : 0);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'((HOLD_CYC > 0) ? HOLD_CYC - 1 : 0);
    localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_WAIT);
    localparam logic [CNT_W-1:0] WR_LD    = CNT_W'(WR_WAIT);

    ebt_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             is_wr;
    logic             bt_q;

    // Phase state, phase counter and latched command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            is_wr  <= 1'b0;
            bt_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else begin
            bt_q <= go_rd | go_wr;
            case (state)
                ST_IDLE: begin
                    if (go_rd || go_wr) begin
                        addr_q <= cmd_addr;
                        data_q <= cmd_data;
                        be_q   <= cmd_be;
                        is_wr  <= go_wr;
                        if (SETUP_CYC > 0) begin
                            state <= ST_SETUP;
                            cnt   <= SETUP_LD;
                        end else begin
                            state <= ST_STROBE;
                            cnt   <= go_wr ? WR_LD : RD_LD;
                        end
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_STROBE;
                        cnt   <= is_wr ? WR_LD : RD_LD;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_STROBE: begin
                    if (cnt == '0) begin
                        if (is_wr && (HOLD_CYC > 0)) begin
                            state <= ST_HOLD;
                            cnt   <= HOLD_LD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decoded phase outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        strobe_rd = (state == ST_STROBE) && !is_wr;
        strobe_wr = (state == ST_STROBE) && is_wr;
        rd_done   = strobe_rd && (cnt == '0);
        begin_x   = bt_q;
    end

    AST_BEGIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        begin_x |=> !begin_x); // R11
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(go_rd || go_wr)); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> ($stable(addr_q) && $stable(data_q))); // R4
    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && $past(state) == ST_IDLE) |-> (SETUP_CYC == 0)); // R2

endmodule

// File: rtl/ebt_rdtrack.sv
// Read tracker: delays each read completion by the effective latency,
// counts pending reads against the limit, and times the read-to-write gap
// from read acceptance. Assumes rd_acc never pulses while pend_full is set.
module ebt_rdtrack
    import ebt_pkg::*;
#(
    parameter int MAX_PEND = 2,
    parameter int RD_LAT   = 3,
    parameter int TURN_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_acc,
    input  logic wr_acc,
    input  logic rd_done,
    output logic rvalid,
    output logic pend_full,
    output logic pend_any,
    output logic turn_busy
);

    localparam int EFF = RD_LAT + 2;
    localparam int GAP = imax(TURN_CYC, EFF);
    localparam int PW  = $clog2(MAX_PEND + 1);
    localparam int TW  = $clog2(GAP + 1);

    logic [EFF-1:0] ret_sr;
    logic [PW-1:0]  pend;
    logic [TW-1:0]  tcnt;

    // Return delay line: one bit per register stage of latency
    always_ff @(posedge clk) begin
        if (!rst_n) ret_sr <= '0;
        else        ret_sr <= {ret_sr[EFF-2:0], rd_done};
    end

    // Pending-read count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            case ({rd_acc, rvalid})
                2'b10:   pend <= pend + PW'(1);
                2'b01:   pend <= pend - PW'(1);
                default: pend <= pend;
            endcase
        end
    end

    // Turnaround counter, restarted by each accepted read
    always_ff @(posedge clk) begin
        if (!rst_n)            tcnt <= '0;
        else if (rd_acc)       tcnt <= TW'(GAP - 1);
        else if (tcnt != '0)   tcnt <= tcnt - TW'(1);
    end

    // Status decode
    always_comb begin
        rvalid    = ret_sr[EFF-1];
        pend_full = (pend >= PW'(MAX_PEND));
        pend_any  = (pend != '0);
        turn_busy = (tcnt != '0);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PW'(MAX_PEND)); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> pend_any); // R5
    AST_NO_ACC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pend_full |-> !rd_acc); // R7
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        turn_busy |-> !wr_acc); // R6

endmodule

// File: rtl/ebt_pins.sv
// Pin register stage: registers every outgoing bus signal with its own
// polarity applied, and registers incoming read data once.
// Assumes the internal signals are active-high.
module ebt_pins #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int BE_W    = 2,
    parameter bit INV_RD  = 1'b1,
    parameter bit INV_WR  = 1'b1,
    parameter bit INV_CS  = 1'b1,
    parameter bit INV_BE  = 1'b0,
    parameter bit INV_OE  = 1'b1,
    parameter bit INV_WBE = 1'b1,
    parameter bit INV_BT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              oe_i,
    input  logic              bt_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [BE_W-1:0]   wbe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] dout_i,
    input  logic [DATA_W-1:0] din_pin,
    output logic              cs_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              oe_o,
    output logic              bt_o,
    output logic [BE_W-1:0]   be_o,
    output logic [BE_W-1:0]   wbe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] dout_o,
    output logic [DATA_W-1:0] din_q
);

    localparam logic [BE_W-1:0] BE_MASK  = {BE_W{INV_BE}};
    localparam logic [BE_W-1:0] WBE_MASK = {BE_W{INV_WBE}};

    // Outgoing register with polarity inversion at the pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_o   <= INV_CS;
            rd_o   <= INV_RD;
            wr_o   <= INV_WR;
            oe_o   <= INV_OE;
            bt_o   <= INV_BT;
            be_o   <= BE_MASK;
            wbe_o  <= WBE_MASK;
            addr_o <= '0;
            dout_o <= '0;
        end else begin
            cs_o   <= cs_i ^ INV_CS;
            rd_o   <= rd_i ^ INV_RD;
            wr_o   <= wr_i ^ INV_WR;
            oe_o   <= oe_i ^ INV_OE;
            bt_o   <= bt_i ^ INV_BT;
            be_o   <= be_i ^ BE_MASK;
            wbe_o  <= wbe_i ^ WBE_MASK;
            addr_o <= addr_i;
            dout_o <= dout_i;
        end
    end

    // Incoming read-data register
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= din_pin;
    end

endmodule

// File: rtl/ext_bus_timer.sv
// External bus timing controller top: accepts slave commands when idle and
// not stalled, sequences them onto the pin stage, and returns read data.
// Assumes the slave never raises s_read and s_write together.
module ext_bus_timer #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SETUP_CYC   = 1,
    parameter int RD_WAIT     = 1,
    parameter int WR_WAIT     = 2,
    parameter int HOLD_CYC    = 2,
    parameter int TURN_CYC    = 7,
    parameter int RD_LAT      = 3,
    parameter int MAX_PEND    = 2,
    parameter bit CS_THRU_LAT = 1'b1,
    parameter bit INV_RD      = 1'b1,
    parameter bit INV_WR      = 1'b1,
    parameter bit INV_CS      = 1'b1,
    parameter bit INV_BE      = 1'b0,
    parameter bit INV_OE      = 1'b1,
    parameter bit INV_WBE     = 1'b1,
    parameter bit INV_BT      = 1'b0,
    localparam int BE_W       = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [BE_W-1:0]   s_be,
    input  logic              s_read,
    input  logic              s_write,
    output logic              s_waitreq,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_rvalid,
    output logic [ADDR_W-1:0] p_addr,
    output logic [DATA_W-1:0] p_dout,
    input  logic [DATA_W-1:0] p_din,
    output logic              p_cs,
    output logic              p_rd,
    output logic              p_wr,
    output logic              p_oe,
    output logic [BE_W-1:0]   p_be,
    output logic [BE_W-1:0]   p_wbe,
    output logic              p_bt
);

    logic              busy, strobe_rd, strobe_wr, begin_x, rd_done;
    logic              pend_full, pend_any, turn_busy;
    logic              go_rd, go_wr, cs_i;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [BE_W-1:0]   be_q, be_i, wbe_i;

    // Command acceptance and internal strobe shaping
    always_comb begin
        s_waitreq = busy | (s_read & pend_full) | (s_write & turn_busy);
        go_rd     = s_read & ~s_waitreq;
        go_wr     = s_write & ~s_read & ~s_waitreq;
        cs_i      = busy | (CS_THRU_LAT & pend_any);
        be_i      = busy ? be_q : '0;
        wbe_i     = strobe_wr ? be_q : '0;
    end

    ebt_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
        .SETUP_CYC(SETUP_CYC), .RD_WAIT(RD_WAIT),
        .WR_WAIT(WR_WAIT), .HOLD_CYC(HOLD_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .go_rd(go_rd), .go_wr(go_wr),
        .cmd_addr(s_addr), .cmd_data(s_wdata), .cmd_be(s_be),
        .busy(busy), .strobe_rd(strobe_rd), .strobe_wr(strobe_wr),
        .begin_x(begin_x), .rd_done(rd_done),
        .addr_q(addr_q), .data_q(data_q), .be_q(be_q)
    );

    ebt_rdtrack #(
        .MAX_PEND(MAX_PEND), .RD_LAT(RD_LAT), .TURN_CYC(TURN_CYC)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .rd_acc(go_rd), .wr_acc(go_wr),
        .rd_done(rd_done), .rvalid(s_rvalid), .pend_full(pend_full),
        .pend_any(pend_any), .turn_busy(turn_busy)
    );

    ebt_pins #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
        .INV_RD(INV_RD), .INV_WR(INV_WR), .INV_CS(INV_CS), .INV_BE(INV_BE),
        .INV_OE(INV_OE), .INV_WBE(INV_WBE), .INV_BT(INV_BT)
    ) u_pins (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .rd_i(strobe_rd),
        .wr_i(strobe_wr), .oe_i(strobe_rd), .bt_i(begin_x),
        .be_i(be_i), .wbe_i(wbe_i), .addr_i(addr_q), .dout_i(data_q),
        .din_pin(p_din), .cs_o(p_cs), .rd_o(p_rd), .wr_o(p_wr),
        .oe_o(p_oe), .bt_o(p_bt), .be_o(p_be), .wbe_o(p_wbe),
        .addr_o(p_addr), .dout_o(p_dout), .din_q(s_rdata)
    );

endmodule

// File: tb/ext_bus_timer_tb_top.sv
// Bench: fixed-latency memory model on the pins, per-cycle pin monitor,
// directed corner cases and a sweep of all four-command orderings.
module ext_bus_timer_tb_top;

    localparam int  SETUP = 1, RDW = 1, WRW = 2, HOLD = 2, TURN = 7;
    localparam int  RDL = 3, MAXP = 2;
    localparam bit  IRD = 1, IWR = 1, ICS = 1, IBE = 0, IOE = 1, IWBE = 1, IBT = 0;
    localparam int  GAP   = (TURN > RDL + 2) ? TURN : RDL + 2;
    localparam int  RTRIP = SETUP + RDW + RDL + 3;
    localparam int  RDSP  = 2 + SETUP + RDW;
    localparam int  WRSP  = 2 + SETUP + WRW + HOLD;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  s_addr = '0;
    logic [15:0] s_wdata = '0;
    logic [1:0]  s_be = '0;
    logic        s_read = 1'b0, s_write = 1'b0;
    logic        s_waitreq, s_rvalid, p_cs, p_rd, p_wr, p_oe, p_bt;
    logic [15:0] s_rdata, p_dout, p_din;
    logic [7:0]  p_addr;
    logic [1:0]  p_be, p_wbe;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ext_bus_timer #(
        .ADDR_W(8), .DATA_W(16), .SETUP_CYC(SETUP), .RD_WAIT(RDW),
        .WR_WAIT(WRW), .HOLD_CYC(HOLD), .TURN_CYC(TURN), .RD_LAT(RDL),
        .MAX_PEND(MAXP), .CS_THRU_LAT(1'b1), .INV_RD(IRD), .INV_WR(IWR),
        .INV_CS(ICS), .INV_BE(IBE), .INV_OE(IOE), .INV_WBE(IWBE), .INV_BT(IBT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_be(s_be), .s_read(s_read), .s_write(s_write),
        .s_waitreq(s_waitreq), .s_rdata(s_rdata), .s_rvalid(s_rvalid),
        .p_addr(p_addr), .p_dout(p_dout), .p_din(p_din), .p_cs(p_cs),
        .p_rd(p_rd), .p_wr(p_wr), .p_oe(p_oe), .p_be(p_be),
        .p_wbe(p_wbe), .p_bt(p_bt)
    );

    function automatic logic [15:0] memf(input logic [7:0] a);
        return {a ^ 8'h5A, a};
    endfunction

    // Fixed-latency memory: drives data RDL cycles after each strobe cycle
    logic       vld_p [RDL];
    logic [7:0] adr_p [RDL];
    always @(posedge clk) begin
        vld_p[0] <= (p_rd ^ IRD);
        adr_p[0] <= p_addr;
        for (int k = 1; k < RDL; k++) begin
            vld_p[k] <= vld_p[k-1];
            adr_p[k] <= adr_p[k-1];
        end
    end
    assign p_din = vld_p[RDL-1] ? memf(adr_p[RDL-1]) : 16'h0000;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_up();
        end
    end

    // Monitor state
    int          bt_cyc = -100, last_acc = -100, last_rd = -100;
    int          rd_len = 0, wr_len = 0, hold_left = 0, pend_m = 0, pend_prev = 0;
    bit          bt_prev = 0, rd_prev = 0, wr_prev = 0;
    logic [7:0]  cur_addr = '0;
    logic [15:0] cur_data = '0;
    logic [1:0]  cur_be = '0;
    logic [7:0]  q_addr [64];
    int          q_acc [64];
    int          q_head = 0, q_tail = 0;

    // Per-cycle pin and response checks, sampled after inputs settle
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            automatic bit rd_a = p_rd ^ IRD;
            automatic bit wr_a = p_wr ^ IWR;
            automatic bit cs_a = p_cs ^ ICS;
            automatic bit oe_a = p_oe ^ IOE;
            automatic bit bt_a = p_bt ^ IBT;
            automatic logic [1:0] wbe_a = p_wbe ^ {2{IWBE}};
            automatic int pv = pend_prev;
            pend_prev = pend_m;
            if (bt_a) begin
                chk(!bt_prev, "R11 single pulse", int'(bt_prev), 0);
                chk(cyc == last_acc + 2, "R11 position", cyc, last_acc + 2);
                chk(cs_a, "R2 cs at begin", int'(cs_a), 1);
                chk(p_bt == 1'b1, "R9 begin level", int'(p_bt), 1);
                bt_cyc = cyc;
            end
            if (oe_a != rd_a) chk(0, "R10 oe follows rd", int'(oe_a), int'(rd_a));
            if (!wr_a && wbe_a != 2'b00) chk(0, "R10 wbe idle", int'(wbe_a), 0);
            if (pv != 0 && !cs_a) chk(0, "R8 cs through pending", 0, 1);
            if (rd_a && !rd_prev) begin
                chk(cyc - bt_cyc == SETUP, "R2 read setup", cyc - bt_cyc, SETUP);
                chk(p_addr == cur_addr, "R2 read addr", int'(p_addr), int'(cur_addr));
                chk(p_rd == 1'b0, "R9 read strobe level", int'(p_rd), 0);
                rd_len = 0;
            end
            if (rd_a) rd_len++;
            if (!rd_a && rd_prev) chk(rd_len == 1 + RDW, "R3 read strobe", rd_len, 1 + RDW);
            if (wr_a && !wr_prev) begin
                chk(cyc - bt_cyc == SETUP, "R2 write setup", cyc - bt_cyc, SETUP);
                chk(p_addr == cur_addr, "R2 write addr", int'(p_addr), int'(cur_addr));
                chk(p_dout == cur_data, "R2 write data", int'(p_dout), int'(cur_data));
                chk(wbe_a == cur_be, "R10 wbe in strobe", int'(wbe_a), int'(cur_be));
                wr_len = 0;
            end
            if (wr_a) wr_len++;
            if (!wr_a && wr_prev) begin
                chk(wr_len == 1 + WRW, "R3 write strobe", wr_len, 1 + WRW);
                hold_left = HOLD;
            end
            if (hold_left > 0 && !wr_a) begin
                chk(cs_a && p_addr == cur_addr && p_dout == cur_data, "R4 hold drive",
                    int'(p_addr), int'(cur_addr));
                hold_left--;
            end
            if (s_rvalid) begin
                chk(q_head != q_tail, "R5 unexpected response", 1, 0);
                chk(cyc == q_acc[q_head % 64] + RTRIP, "R5 return cycle", cyc,
                    q_acc[q_head % 64] + RTRIP);
                chk(s_rdata == memf(q_addr[q_head % 64]), "R5 return data",
                    int'(s_rdata), int'(memf(q_addr[q_head % 64])));
                q_head++;
                pend_m--;
            end
            if (s_read && pend_m >= MAXP) chk(s_waitreq, "R7 stall at limit", int'(s_waitreq), 1);
            if (s_write && cyc - last_rd < GAP)
                chk(s_waitreq, "R6 stall in gap", int'(s_waitreq), 1);
            if (s_read && !s_waitreq) begin
                chk(pend_m < MAXP, "R7 accept under limit", pend_m, MAXP - 1);
                q_addr[q_tail % 64] = s_addr;
                q_acc[q_tail % 64]  = cyc;
                q_tail++;
                pend_m++;
                last_rd = cyc; last_acc = cyc; cur_addr = s_addr;
            end else if (s_write && !s_waitreq) begin
                chk(cyc - last_rd >= GAP, "R6 gap honoured", cyc - last_rd, GAP);
                last_acc = cyc; cur_addr = s_addr; cur_data = s_wdata; cur_be = s_be;
            end
            bt_prev = bt_a; rd_prev = rd_a; wr_prev = wr_a;
        end
    end

    int acc_cyc;

    // Presents one command (called at a falling edge) and waits for acceptance
    task automatic op(input bit w, input logic [7:0] a, input logic [1:0] b);
        s_read = !w; s_write = w; s_addr = a; s_wdata = {~a, a}; s_be = b;
        forever begin
            #1;
            if (!s_waitreq) break;
            @(negedge clk);
        end
        acc_cyc = cyc;
        @(negedge clk);
        s_read = 1'b0; s_write = 1'b0;
    endtask

    initial begin
        int t1, t2, t3;
        repeat (3) @(negedge clk);
        #2;
        chk(p_cs == ICS && p_rd == IRD && p_wr == IWR, "R1 reset strobes",
            int'({p_cs, p_rd, p_wr}), int'({ICS, IRD, IWR}));
        chk(p_oe == IOE && p_bt == IBT && p_wbe == {2{IWBE}} && p_be == {2{IBE}},
            "R1 reset enables", int'(p_oe), int'(IOE));
        chk(!s_rvalid, "R1 reset rvalid", int'(s_rvalid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        chk(!s_waitreq, "R1 idle waitreq", int'(s_waitreq), 0);
        chk(p_cs == ICS, "R8 idle cs", int'(p_cs), int'(ICS));
        @(negedge clk);

        // Back-to-back writes: hold phase sets the spacing
        op(1, 8'h21, 2'b11); t1 = acc_cyc;
        op(1, 8'h22, 2'b01); t2 = acc_cyc;
        chk(t2 - t1 == WRSP, "R4 write spacing", t2 - t1, WRSP);
        repeat (20) @(negedge clk);

        // Three back-to-back reads: third meets the pending limit
        op(0, 8'h31, 2'b11); t1 = acc_cyc;
        op(0, 8'h32, 2'b11); t2 = acc_cyc;
        op(0, 8'h33, 2'b11); t3 = acc_cyc;
        chk(t2 - t1 == RDSP, "R4 read spacing", t2 - t1, RDSP);
        chk(t3 - t1 == ((2 * RDSP > RTRIP + 1) ? 2 * RDSP : RTRIP + 1),
            "R7 third read timing", t3 - t1,
            (2 * RDSP > RTRIP + 1) ? 2 * RDSP : RTRIP + 1);
        repeat (20) @(negedge clk);

        // Read then write: turnaround from read acceptance
        op(0, 8'h41, 2'b11); t1 = acc_cyc;
        op(1, 8'h42, 2'b10); t2 = acc_cyc;
        chk(t2 - t1 == ((GAP > RDSP) ? GAP : RDSP), "R6 exact gap", t2 - t1,
            (GAP > RDSP) ? GAP : RDSP);
        repeat (20) @(negedge clk);

        // Every ordering of four reads and writes
        for (int pat = 0; pat < 16; pat++) begin
            for (int k = 0; k < 4; k++) begin
                op(pat[k], 8'(pat * 4 + k + 64), 2'(pat + k));
            end
        end
        repeat (30) @(negedge clk);
        #2;
        chk(q_head == q_tail, "R5 all responses returned", q_tail - q_head, 0);
        chk(p_cs == ICS, "R8 cs released", int'(p_cs), int'(ICS));
        finish_up();
    end

endmodule